// File: doc/BRIEF.md
# Add/Subtract Unit with Corrected-Sign Carry Flag

This block is the integer adder of a processor datapath. Each cycle in which `in_valid` is high, it takes a destination operand, a source operand, a four-bit operation code and the current carry and zero flags. On the next clock edge it registers four outputs:

- a result word;
- a write-enable for that word;
- new carry and zero flag values.

One adder serves every arithmetic operation. The forms differ only in three things: whether the source is inverted, where the carry-in comes from, and how the carry output is derived.

For unsigned forms the carry output is a plain carry or borrow. For signed add, subtract and compare, the carry output is the exact sign of the full-precision answer. That is bit W of the sign-extended sum, so it stays correct when the W-bit result overflows. Software recovers overflow as `result[W-1] ^ c_out`, and the bit-test-with-XOR operation performs exactly that step. Two Z-steered sum operations report signed overflow directly in C.

Extended forms chain a carry or borrow in from `c_in` and AND their zero test with `z_in`. Multi-word arithmetic therefore works as follows: the low words use unsigned extended forms, and only the top word uses a signed form.

Top module: `addsub_flags_unit`

## Requirements
- R1: Opcode 0 (add) writes `d_in + s_in` and sets C to bit W of the zero-extended sum. Opcode 1 (add-extended) also adds `c_in`.
- R2: Opcode 4 (subtract) and opcode 8 (compare) form `d_in - s_in` and set C to 1 exactly when `d_in` < `s_in` as unsigned values.
- R3: Opcode 2 (signed add) sets C to the sign of the exact sum of the two signed operands. With no overflow this is result bit W-1, and with overflow it is the inverse of that bit.
- R4: Opcode 6 (signed subtract) and opcode 10 (signed compare) set C to 1 exactly when `d_in` < `s_in` as signed values.
- R5: The compare opcodes 8, 9, 10 and 11 produce the same C and Z as subtract opcodes 4, 5, 6 and 7 respectively, with `wr_en` low. Opcodes 0 to 7, 12 and 13 raise `wr_en`.
- R6: The non-extended arithmetic opcodes 0, 2, 4, 6, 8, 10, 12 and 13 set Z to 1 exactly when the W-bit result is zero.
- R7: The extended opcodes behave as follows:
  - Opcodes 1 (add) and 3 (signed add) add `c_in`.
  - Opcodes 5 and 9 (unsigned subtract/compare) and opcodes 7 and 11 (signed subtract/compare) subtract `c_in`.
  - Their C follows the matching unsigned or signed rule on the exact value `d - s - c_in` or `d + s + c_in`.
  - Their Z is `z_in` AND (result == 0).
- R8: Opcode 12 adds when `z_in` = 1 and subtracts when `z_in` = 0. Opcode 13 does the opposite. Both set C to signed overflow of the W-bit result.
- R9: Opcodes 14 and 15 are bit tests on bit `s_in[log2(W)-1:0]` of `d_in`:
  - Opcode 14 sets C = `c_in` XOR that bit.
  - Opcode 15 sets C = that bit.
  - Both pass Z through from `z_in`, drive `result` = `d_in`, and hold `wr_en` low.
- R10: All outputs are registered. `out_valid` is `in_valid` delayed by one clock. When `in_valid` is low, the other outputs keep their values. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| d_in | input | W | Destination operand |
| s_in | input | W | Source operand or bit index |
| c_in | input | 1 | Incoming carry flag |
| z_in | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | W | Result word |
| wr_en | output | 1 | Result should be written back |
| c_out | output | 1 | New carry / corrected sign / overflow flag |
| z_out | output | 1 | New zero flag |

## Verification
The assertions compare each output with the inputs of the previous cycle through `$past`. They therefore assume that the inputs are stable and known at every rising edge, and that `in_valid` is low while reset is asserted. The stimulus meets both assumptions: it changes inputs only on the falling edge and holds the strobe low through reset. Every one of the sixteen opcodes is defined, so random opcodes never leave the checked space. The stimulus mixes boundary words (0, 1, 7FFFFFFF, 80000000, FFFFFFFF and their neighbours) with random words, and sweeps both `c_in` and `z_in`. This exercises carry chaining and the Z-steered direction in both polarities.

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] s_in,
  input  logic         c_in,
  input  logic         z_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         c_out,
  output logic         z_out
);
  localparam int BW = $clog2(W);

  localparam logic [3:0] OP_ADD   = 4'd0,  OP_ADDX  = 4'd1,  OP_ADDS  = 4'd2,  OP_ADDSX = 4'd3;
  localparam logic [3:0] OP_SUB   = 4'd4,  OP_SUBX  = 4'd5,  OP_SUBS  = 4'd6,  OP_SUBSX = 4'd7;
  localparam logic [3:0] OP_CMP   = 4'd8,  OP_CMPX  = 4'd9,  OP_CMPS  = 4'd10, OP_CMPSX = 4'd11;
  localparam logic [3:0] OP_SUMZ  = 4'd12, OP_SUMNZ = 4'd13, OP_TBX   = 4'd14, OP_TB    = 4'd15;

  // operation class decode
  wire is_sum  = (op == OP_SUMZ) || (op == OP_SUMNZ);
  wire is_tb   = (op == OP_TBX)  || (op == OP_TB);
  wire is_arith = !is_tb;
  wire is_ext  = !op[3] ? op[0] : (!op[2] && op[0]);
  wire is_sgn  = !op[3] ? op[1] : (!op[2] && op[1]);
  wire is_cmp  = op[3] && !op[2];
  wire sum_sub = (op == OP_SUMZ) ? !z_in : z_in;
  wire do_sub  = is_sum ? sum_sub : (op[2] || op[3]);
  wire cin     = is_ext ? c_in : 1'b0;

  // one shared adder: subtraction is d + ~s + ~cin
  wire [W-1:0] xs  = do_sub ? ~s_in : s_in;
  wire         k   = do_sub ? ~cin : cin;
  wire [W:0]   raw = {1'b0, d_in} + {1'b0, xs} + {{W{1'b0}}, k};
  wire [W-1:0] sum = raw[W-1:0];

  wire c_uns   = do_sub ? ~raw[W] : raw[W];
  wire c_sgn   = raw[W] ^ d_in[W-1] ^ xs[W-1];
  wire ovf     = c_sgn ^ sum[W-1];
  wire sum_zero = (sum == '0);

  wire tbit    = d_in[s_in[BW-1:0]];

  logic         c_nx, z_nx;
  logic [W-1:0] r_nx;

  always_comb begin
    r_nx = sum;
    z_nx = is_ext ? (z_in & sum_zero) : sum_zero;
    if (is_sum)      c_nx = ovf;
    else if (is_sgn) c_nx = c_sgn;
    else             c_nx = c_uns;
    if (is_tb) begin
      r_nx = d_in;
      z_nx = z_in;
      c_nx = (op == OP_TBX) ? (c_in ^ tbit) : tbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      c_out     <= 1'b0;
      z_out     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= r_nx;
        wr_en  <= is_arith && !is_cmp;
        c_out  <= c_nx;
        z_out  <= z_nx;
      end
    end
  end

  // R2: unsigned subtract/compare borrow
  assert_unsigned_borrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && ($past(op) == OP_SUB || $past(op) == OP_CMP)
      |-> c_out == ($past(d_in) < $past(s_in)));

  // R4: signed subtract/compare gives signed less-than
  assert_signed_less_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && ($past(op) == OP_SUBS || $past(op) == OP_CMPS)
      |-> c_out == ($signed($past(d_in)) < $signed($past(s_in))));

  // R5: compares never request a write
  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && $past(op[3:2]) == 2'b10 |-> !wr_en);

  // R6: plain arithmetic Z tracks a zero result
  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && !$past(op[0]) && $past(op) != OP_TBX
      |-> z_out == (result == '0));

  // R7: extended Z can only stay set
  assert_ext_zero_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && $past(is_ext) && z_out |-> $past(z_in));

  // R9: bit test XOR into carry
  assert_bit_xor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) && $past(op) == OP_TBX
      |-> c_out == ($past(c_in) ^ $past(|(d_in & (W'(1) << s_in[BW-1:0])))));

  // R10: registered handshake and hold
  assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(result) && $stable(c_out) && $stable(z_out) && $stable(wr_en));
endmodule

// File: tb/sim_addsub_flags_unit.sv
module sim_addsub_flags_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         we;
    logic         c;
    logic         z;
    string        tag;
    string        ztag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] d_in = '0, s_in = '0;
  logic         c_in = 1'b0, z_in = 1'b0;
  logic         out_valid, wr_en, c_out, z_out;
  logic [W-1:0] result;

  int checks = 0, fails = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_flags_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .d_in(d_in), .s_in(s_in),
    .c_in(c_in), .z_in(z_in), .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .c_out(c_out), .z_out(z_out));

  function automatic exp_t model(input logic [3:0] o, input logic [W-1:0] d, input logic [W-1:0] s,
                                 input logic ci, input logic zi);
    exp_t e;
    longint sd = longint'($signed(d)), ss = longint'($signed(s));
    longint ud = longint'({32'b0, d}), us = longint'({32'b0, s});
    longint t;
    bit ext = (o < 12) && o[0];
    longint cin = (ext && ci) ? 1 : 0;
    bit add;
    e.we = (o < 8) || o == 12 || o == 13;
    case (o)
      0, 1:           begin t = ud + us + cin; e.c = (t > 64'h0FFFF_FFFF); e.tag = (o == 0) ? "R1" : "R7"; end
      2, 3:           begin t = sd + ss + cin; e.c = (t < 0); e.tag = (o == 2) ? "R3" : "R7"; end
      4, 5, 8, 9:     begin t = ud - us - cin; e.c = (t < 0); e.tag = ext ? "R7" : (o == 8 ? "R5" : "R2"); end
      6, 7, 10, 11:   begin t = sd - ss - cin; e.c = (t < 0); e.tag = ext ? "R7" : (o == 10 ? "R5" : "R4"); end
      12, 13: begin
        add = (o == 12) ? zi : !zi;
        t = add ? sd + ss : sd - ss;
        e.c = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        e.tag = "R8";
      end
      default: begin
        t = longint'({32'b0, d});
        e.c = (o == 14) ? (ci ^ d[s[4:0]]) : d[s[4:0]];
        e.tag = "R9";
      end
    endcase
    e.res = t[W-1:0];
    if (o >= 14) begin e.z = zi; e.ztag = "R9"; end
    else if (ext) begin e.z = zi && (e.res == 0); e.ztag = "R7"; end
    else begin e.z = (e.res == 0); e.ztag = "R6"; end
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [W-1:0] d, input logic [W-1:0] s,
                       input logic ci, input logic zi);
    @(negedge clk);
    op = o; d_in = d; s_in = s; c_in = ci; z_in = zi; in_valid = 1'b1;
    q.push_back(model(o, d, s, ci, zi));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      d_in = $urandom; s_in = $urandom; op = 4'($urandom); c_in = ~c_in; z_in = ~z_in;
    end
  endtask

  // monitor: compare registered outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        exp_t e;
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10 out_valid=1 with nothing expected (actual 1, expected 0)");
        end else begin
          e = q.pop_front();
          checks++;
          if (result !== e.res || wr_en !== e.we || c_out !== e.c) begin
            fails++;
            $display("FAIL %s res/we/c actual %h/%b/%b expected %h/%b/%b",
                     e.tag, result, wr_en, c_out, e.res, e.we, e.c);
          end
          checks++;
          if (z_out !== e.z) begin
            fails++;
            $display("FAIL %s z actual %b expected %b", e.ztag, z_out, e.z);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired (actual running, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [W-1:0] corner [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                               32'hFFFFFFFF, 32'h7FFFFFFE, 32'h80000001, 32'h5};

  initial begin
    logic [W-1:0] hold_r;
    logic hold_c, hold_z, hold_w;
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (out_valid !== 0 || result !== 0 || wr_en !== 0 || c_out !== 0 || z_out !== 0) begin
      fails++;
      $display("FAIL R10 reset outputs actual %b/%h/%b/%b/%b expected all zero",
               out_valid, result, wr_en, c_out, z_out);
    end
    rst_n = 1'b1;

    // R2 R4 R5 R6: flag examples for equal, overflowing and small operands
    for (int o = 4; o <= 10; o += 2) begin
      drive(4'(o), 32'h80000000, 32'h80000000, 1'b0, 1'b0);
      drive(4'(o), 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0);
      drive(4'(o), 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0);
      drive(4'(o), 32'h4, 32'h5, 1'b0, 1'b0);
      drive(4'(o), 32'h80000001, 32'h80000000, 1'b0, 1'b0);
    end
    // R8: overflow cases and their non-overflowing neighbours
    drive(4'd13, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b1);
    drive(4'd13, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b1);
    drive(4'd12, 32'h80000000, 32'h1, 1'b0, 1'b0);
    drive(4'd12, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0);
    drive(4'd12, 32'h7FFFFFFE, 32'h1, 1'b0, 1'b1);
    drive(4'd13, 32'h80000001, 32'h1, 1'b0, 1'b1);
    // R9: sign-to-overflow conversion after a signed add
    drive(4'd2, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b0);
    drive(4'd14, 32'h80000000, 32'd31, 1'b0, 1'b0);
    drive(4'd15, 32'h00000100, 32'd8, 1'b0, 1'b1);
    // R1 R7: 64-bit chain FFFFFFFF_FFFFFFFF + 00000000_00000001 using low add then signed add-extended
    drive(4'd0, 32'hFFFFFFFF, 32'h1, 1'b0, 1'b0);
    drive(4'd3, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b1);
    drive(4'd9, 32'h0, 32'h0, 1'b1, 1'b1);
    drive(4'd11, 32'h0, 32'h0, 1'b0, 1'b1);
    // corner sweep over every opcode and flag combination
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          drive(4'(o), corner[a], (o >= 14) ? W'(b * 4 + 3) : corner[b], 1'(a + b), 1'(a ^ o));
    // random
    for (int i = 0; i < 400; i++)
      drive(4'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom));
    idle(2);

    // R10: outputs hold while the strobe is low
    drive(4'd0, 32'h12345678, 32'h1, 1'b0, 1'b0);
    idle(1);
    hold_r = result; hold_c = c_out; hold_z = z_out; hold_w = wr_en;
    idle(3);
    checks++;
    if (out_valid !== 0 || result !== hold_r || c_out !== hold_c || z_out !== hold_z || wr_en !== hold_w) begin
      fails++;
      $display("FAIL R10 hold actual %b/%h expected 0/%h", out_valid, result, hold_r);
    end
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10 pending results actual %0d expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule